// File: doc/BRIEF.md
# Supply Trim Ramp Sequencer

This block walks a supply-voltage trim code down to a safe level before a sensitive operation, such as programming one-time fuses. Later it walks the code back up to where it was. The code only ever moves by one step. Each step is followed by a dwell so the regulator can follow, and every ramp ends with a longer settle period before completion is signalled. The regulator itself is outside this block: the block only produces the code that drives it.

A ramp begins when `start_i` is high while the block is idle. The direction input selects the ramp:

- **Enter ramp** (`dir_enter_i` = 1). The block loads the code present on `trim_i` into both the output register and a saved-original register. It then counts the output down to the floor code.
- **Exit ramp** (`dir_enter_i` = 0). The block counts the output up from its present value to the saved original.

The control is one state machine with four states:

| State | What it does |
|-------|--------------|
| IDLE | Waits for a start request. |
| DECIDE | Takes one step, or decides that no step is needed. |
| DWELL | Waits the dwell time after a step. |
| SETTLE | Waits the final settle time. |

The transitions are:

| From | To | Condition |
|------|----|-----------|
| IDLE | DECIDE | `start_i` is high. |
| DECIDE | DWELL | A step is needed. The code moves by one in the same edge. |
| DECIDE | SETTLE | No step is needed. |
| DWELL | DECIDE | The dwell timer has expired. |
| SETTLE | IDLE | The settle timer has expired. `done_o` pulses for one cycle. |

Top module: `trim_ramp_seq`

## Requirements
- R1: After reset, `trim_o` is 0 and `done_o` is 0.
- R2: A start request with `dir_enter_i` = 1, taken while idle, loads `trim_i` into `trim_o` and into the saved original at that clock edge.
- R3: During an enter ramp, `trim_o` falls by exactly one per step while it is above `FLOOR_CODE` (default 2), and it stops at `FLOOR_CODE`. A loaded code at or below the floor produces no steps.
- R4: A start request with `dir_enter_i` = 0 raises `trim_o` by exactly one per step from its present value until it equals the saved original. If the present value is already at or above the original, no step is made.
- R5: The first step lands one edge after the start edge. Consecutive steps are `DWELL_CYC`+1 edges apart.
- R6: For a ramp of N steps, `done_o` is high for exactly one cycle. That cycle follows the edge that lies 1+N·(`DWELL_CYC`+1)+`SETTLE_CYC` edges after the start edge.
- R7: A start request, together with its direction and trim values, has no effect on `trim_o` or on the timing of `done_o` while a ramp is in progress.
- R8: While idle with no start request, `trim_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. |
| rst_n | input | 1 | Asynchronous active-low reset. |
| start_i | input | 1 | Ramp request. It is sampled only while idle. |
| dir_enter_i | input | 1 | Ramp direction: 1 selects the enter (down) ramp, 0 selects the exit (up) ramp. |
| trim_i | input | CODE_W | Present trim code. It is captured on an enter request. |
| trim_o | output | CODE_W | Trim code driven to the regulator. |
| done_o | output | 1 | One-cycle pulse that marks the end of the settle period. |

## Verification
Every result has a fixed arrival time, counted in edges from the start edge:

- The loaded code is visible at edge 0.
- Step k lands at edge 1+k·(`DWELL_CYC`+1).
- The done pulse follows edge 1+N·(`DWELL_CYC`+1)+`SETTLE_CYC`.

The bench drives inputs and samples outputs on falling edges. It counts rising edges after the start edge and compares `trim_o` and `done_o` on every cycle against values computed from these formulas. So a step or pulse that arrives one cycle early or late is reported, not just a wrong final code.

The sweep covers every 4-bit starting code in both directions. Some runs raise a second, contrary request in the middle of the ramp, and the bench confirms that the trajectory stays the same.

// File: rtl/trim_ramp_pkg.sv
package trim_ramp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DECIDE = 2'd1,
        ST_DWELL  = 2'd2,
        ST_SETTLE = 2'd3
    } ramp_state_t;

endpackage

// File: rtl/trim_ramp_code.sv
module trim_ramp_code #(
    parameter int CODE_W     = 5,
    parameter int FLOOR_CODE = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [CODE_W-1:0] trim_in,
    input  logic              step_en,
    input  logic              step_up,
    output logic [CODE_W-1:0] code,
    output logic              above_floor,
    output logic              below_orig
);

    localparam logic [CODE_W-1:0] FLOOR_C = CODE_W'(FLOOR_CODE);

    logic [CODE_W-1:0] code_q;
    logic [CODE_W-1:0] orig_q;

    // Output code and saved original
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
            orig_q <= '0;
        end else if (capture) begin
            code_q <= trim_in;
            orig_q <= trim_in;
        end else if (step_en) begin
            if (step_up)
                code_q <= code_q + 1'b1;
            else
                code_q <= code_q - 1'b1;
        end
    end

    assign code        = code_q;
    assign above_floor = (code_q > FLOOR_C);
    assign below_orig  = (code_q < orig_q);

endmodule

// File: rtl/trim_ramp_timer.sv
module trim_ramp_timer #(
    parameter int DWELL_CYC  = 12000,
    parameter int SETTLE_CYC = 240000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_dwell,
    input  logic load_settle,
    output logic expired
);

    localparam int MAX_CYC = (DWELL_CYC > SETTLE_CYC) ? DWELL_CYC : SETTLE_CYC;
    localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
    localparam logic [CNT_W-1:0] DWELL_LD  = CNT_W'(DWELL_CYC - 1);
    localparam logic [CNT_W-1:0] SETTLE_LD = CNT_W'(SETTLE_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    // Down counter: reload, count towards zero, then rest at zero
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_dwell)
            cnt_q <= DWELL_LD;
        else if (load_settle)
            cnt_q <= SETTLE_LD;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/trim_ramp_fsm.sv
module trim_ramp_fsm
    import trim_ramp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic dir_enter_i,
    input  logic above_floor,
    input  logic below_orig,
    input  logic expired,
    output logic capture,
    output logic step_en,
    output logic step_up,
    output logic load_dwell,
    output logic load_settle,
    output logic active,
    output logic done_o
);

    ramp_state_t state_q, state_d;
    logic        dir_q;
    logic        done_q;
    logic        need_step;

    assign need_step = dir_q ? above_floor : below_orig;

    // State register, latched direction and done pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            dir_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q == ST_SETTLE) && expired;
            if (state_q == ST_IDLE && start_i)
                dir_q <= dir_enter_i;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_DECIDE;
            ST_DECIDE: state_d = need_step ? ST_DWELL : ST_SETTLE;
            ST_DWELL:  if (expired) state_d = ST_DECIDE;
            ST_SETTLE: if (expired) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        capture     = (state_q == ST_IDLE) && start_i && dir_enter_i;
        step_en     = (state_q == ST_DECIDE) && need_step;
        step_up     = !dir_q;
        load_dwell  = (state_q == ST_DECIDE) && need_step;
        load_settle = (state_q == ST_DECIDE) && !need_step;
        active      = (state_q != ST_IDLE);
    end

    assign done_o = done_q;

endmodule

// File: rtl/trim_ramp_seq.sv
module trim_ramp_seq #(
    parameter int CODE_W     = 5,
    parameter int FLOOR_CODE = 2,
    parameter int DWELL_CYC  = 12000,
    parameter int SETTLE_CYC = 240000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              dir_enter_i,
    input  logic [CODE_W-1:0] trim_i,
    output logic [CODE_W-1:0] trim_o,
    output logic              done_o
);

    logic capture;
    logic step_en;
    logic step_up;
    logic load_dwell;
    logic load_settle;
    logic active;
    logic above_floor;
    logic below_orig;
    logic expired;

    trim_ramp_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .dir_enter_i (dir_enter_i),
        .above_floor (above_floor),
        .below_orig  (below_orig),
        .expired     (expired),
        .capture     (capture),
        .step_en     (step_en),
        .step_up     (step_up),
        .load_dwell  (load_dwell),
        .load_settle (load_settle),
        .active      (active),
        .done_o      (done_o)
    );

    trim_ramp_code #(
        .CODE_W     (CODE_W),
        .FLOOR_CODE (FLOOR_CODE)
    ) u_code (
        .clk         (clk),
        .rst_n       (rst_n),
        .capture     (capture),
        .trim_in     (trim_i),
        .step_en     (step_en),
        .step_up     (step_up),
        .code        (trim_o),
        .above_floor (above_floor),
        .below_orig  (below_orig)
    );

    trim_ramp_timer #(
        .DWELL_CYC  (DWELL_CYC),
        .SETTLE_CYC (SETTLE_CYC)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_dwell  (load_dwell),
        .load_settle (load_settle),
        .expired     (expired)
    );

endmodule

// File: rtl/trim_ramp_chk.sv
module trim_ramp_chk #(
    parameter int CODE_W     = 5,
    parameter int FLOOR_CODE = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              active,
    input logic [CODE_W-1:0] trim_o,
    input logic              done_o
);

    logic [CODE_W:0] cur_x;
    assign cur_x = {1'b0, trim_o};

    // R3 R4: while a ramp runs, the code moves by at most one per cycle
    a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active)) |->
            (cur_x == {1'b0, $past(trim_o)} ||
             cur_x == {1'b0, $past(trim_o)} + 1'b1 ||
             cur_x + 1'b1 == {1'b0, $past(trim_o)}));

    // R3: a falling step never lands below the floor
    a_r3_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active) && trim_o < $past(trim_o)) |->
            (int'(trim_o) >= FLOOR_CODE));

    // R6: done lasts exactly one cycle
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6: done coincides with the return to idle
    a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !active);

    // R8: idle without a request keeps the code
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !start_i) |=> $stable(trim_o));

endmodule

bind trim_ramp_seq trim_ramp_chk #(
    .CODE_W     (CODE_W),
    .FLOOR_CODE (FLOOR_CODE)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .active  (active),
    .trim_o  (trim_o),
    .done_o  (done_o)
);

// File: tb/trim_ramp_seq_test.sv
module trim_ramp_seq_test;

    localparam int CLK_PERIOD = 10;
    localparam int CW   = 4;
    localparam int FLR  = 2;
    localparam int DW   = 3;
    localparam int ST   = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          dir_enter_i = 1'b0;
    logic [CW-1:0] trim_i = '0;
    logic [CW-1:0] trim_o;
    logic          done_o;

    int checks = 0;
    int errors = 0;
    int model_code = 0;
    int model_orig = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trim_ramp_seq #(
        .CODE_W     (CW),
        .FLOOR_CODE (FLR),
        .DWELL_CYC  (DW),
        .SETTLE_CYC (ST)
    ) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .dir_enter_i (dir_enter_i),
        .trim_i      (trim_i),
        .trim_o      (trim_o),
        .done_o      (done_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // One ramp; poke raises a contrary request mid-ramp (R7)
    task automatic do_ramp(input bit enter, input int tin, input bit poke);
        int base;
        int n;
        int lat;
        int steps;
        int exp_code;
        @(negedge clk);
        start_i = 1'b1; dir_enter_i = enter; trim_i = CW'(tin);
        @(negedge clk);
        start_i = 1'b0;
        if (enter) begin
            model_orig = tin;
            base = tin;
            n = (tin > FLR) ? tin - FLR : 0;
        end else begin
            base = model_code;
            n = (model_orig > model_code) ? model_orig - model_code : 0;
        end
        lat = 1 + n * (DW + 1) + ST;
        check(enter ? "R2 load" : "R4 start", int'(trim_o), base);
        check("R6 done low at start", int'(done_o), 0);
        for (int t = 1; t <= lat + 2; t++) begin
            if (poke && (t == 2 || t == 3)) begin
                start_i = 1'b1; dir_enter_i = !enter; trim_i = ~CW'(tin);
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
            steps = (n == 0) ? 0 : (((t - 1) / (DW + 1) + 1 < n) ? (t - 1) / (DW + 1) + 1 : n);
            exp_code = enter ? base - steps : base + steps;
            check(enter ? "R3 R5 R7 down code" : "R4 R5 R7 up code", int'(trim_o), exp_code);
            check("R6 R7 done timing", int'(done_o), (t == lat) ? 1 : 0);
        end
        start_i = 1'b0;
        model_code = enter ? base - n : base + n;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 trim reset", int'(trim_o), 0);
        check("R1 done reset", int'(done_o), 0);
        rst_n = 1'b1;
        // R8 idle hold with moving trim_i
        for (int i = 0; i < 4; i++) begin
            trim_i = CW'(i * 5 + 3);
            @(negedge clk);
            check("R8 idle hold", int'(trim_o), 0);
        end
        // R4 exit from reset: nothing to climb
        do_ramp(1'b0, 0, 1'b0);
        // Full sweep of starting codes, both directions
        for (int v = 0; v < (1 << CW); v++) begin
            do_ramp(1'b1, v, (v % 3) == 0);
            for (int i = 0; i < 3; i++) begin
                trim_i = CW'(v + i + 1);
                @(negedge clk);
                check("R8 idle hold after enter", int'(trim_o), model_code);
            end
            do_ramp(1'b0, 15 - v, (v % 4) == 1);
        end
        // R4 exit with code already at original
        do_ramp(1'b0, 7, 1'b1);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule